// File: doc/BRIEF.md
# PMIC Register Link Bridge

The bridge sits between a simple memory-mapped register bus and a power-management companion chip that is reached over a four-wire serial link. Software stores a 16-bit value into a slave window of the bus map, and the bridge posts it into a write queue. The queue drains one serial frame at a time. Software starts a read by writing a slave offset into a read-command register. It then polls a busy bit and finds the returned data next to the link address that was actually read, so that it can check the answer against the request.

The window size and the way a byte offset maps onto the 15-bit link address are set at run time. Three window sizes are available, and two address mappings: an older one that takes the low offset bits, and a newer one that drops the two always-zero low bits. An access that falls outside the window raises a sticky error and never reaches the link.

Top module: `pmic_link_bridge`

## Requirements
- R1: After reset the read-data register reads 0, the queue status reads 32'h0000_0400 (empty set, full clear), the error register reads 0, link_cs_n is 1 and link_sclk is 0.
- R2: A bus write of an in-window offset to the read-command register (bus_addr[18]=0, bus_addr[4:2]=1) sets busy (read-data bit 31) at that same clock edge. With an idle link and an empty queue, busy clears exactly 1+64*(div+1) clock edges after that write edge.
- R3: The read-data register (index 2) holds the returned data in bits 15:0, the link address of that read in bits 30:16 and busy in bit 31.
- R4: The link address is offset[14:0] when configuration bit 10 is 0, and offset[16:2] when it is 1. The same value is sent on the link and echoed in the read-data register.
- R5: A bus write with bus_addr[18]=1 is a slave write of bus_wdata[15:0] at offset bus_addr[16:0]. It is queued only when the queue is not full; a write to a full queue is dropped.
- R6: The queue status register (index 3) shows full in bit 11 and empty in bit 10. The queue holds 16 entries.
- R7: The window size is chosen by configuration bits 9:8: 0 gives 4 KiB, 1 gives 16 KiB, 2 or 3 give 128 KiB. An offset at or above the size, whether as a slave write or as a read command, starts nothing and sets bit 0 of the error register (index 4). That bit stays set until a write to index 4 with bit 0 high.
- R8: Queued writes leave in the order they were accepted. A pending read starts only once the queue is empty and the link is idle.
- R9: A frame holds link_cs_n low for 32 bits: the direction bit (1 = read), 15 address bits MSB first, then 16 data bits MSB first. link_sdo changes while link_sclk is low, and each bit is sampled on the rising edge. Each half period of link_sclk lasts div+1 clock cycles, where div is configuration bits 7:0. In a read, link_sdi is sampled on the rising edges of the last 16 bits.
- R10: A read command written while busy is set is ignored: the ongoing read keeps its address and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 19 | Byte address; bit 18 selects the slave window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| link_sclk | output | 1 | Serial clock to slave |
| link_cs_n | output | 1 | Frame select, active low |
| link_sdo | output | 1 | Serial data to slave |
| link_sdi | input | 1 | Serial data from slave |

## Verification
Busy becomes visible on the first sample after the command edge. The bench then polls once per cycle and counts edges, so that the clear lands on exactly 1+64*(div+1). A queued write reaches the slave one edge after it is accepted if the link is idle, and otherwise one edge after the previous frame ends. The bench does not time these writes. It compares the order and contents of the frames that its behavioural slave decodes against a queue of the frames it expects. Status and error registers are read back on the cycle after the write that should have changed them.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int LINK_AW = 15;
  localparam int LINK_DW = 16;
  localparam int OFF_W   = 17;

  typedef struct packed {
    logic [LINK_AW-1:0] addr;
    logic [LINK_DW-1:0] data;
  } wr_entry_t;

  // window size in bytes for a mode code
  function automatic logic [OFF_W:0] plb_window_bytes(input logic [1:0] mode);
    case (mode)
      2'd0:    return (OFF_W+1)'(4096);
      2'd1:    return (OFF_W+1)'(16384);
      default: return (OFF_W+1)'(131072);
    endcase
  endfunction

  function automatic logic plb_in_window(input logic [OFF_W-1:0] off, input logic [1:0] mode);
    return {1'b0, off} < plb_window_bytes(mode);
  endfunction

  function automatic logic [LINK_AW-1:0] plb_link_addr(input logic [OFF_W-1:0] off, input logic newmap);
    return newmap ? off[OFF_W-1:2] : off[LINK_AW-1:0];
  endfunction
endpackage

// File: rtl/plb_wfifo.sv
module plb_wfifo #(
  parameter int DEPTH = 16,
  parameter int W     = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/plb_seq.sv
module plb_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pend,
  input  logic fifo_empty,
  input  logic link_active,
  output logic rd_start,
  output logic wr_start,
  output logic cur_rd
);
  assign rd_start = !link_active && rd_pend && fifo_empty;
  assign wr_start = !link_active && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_rd <= 1'b0;
    else if (rd_start) cur_rd <= 1'b1;
    else if (wr_start) cur_rd <= 1'b0;
  end
endmodule

// File: rtl/plb_shifter.sv
module plb_shifter #(
  parameter int AW   = 15,
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_rd,
  input  logic [AW-1:0]   start_addr,
  input  logic [DW-1:0]   start_data,
  input  logic [DIVW-1:0] div,
  output logic            active,
  output logic            done,
  output logic [DW-1:0]   rx_data,
  output logic            sclk,
  output logic            cs_n,
  output logic            sdo,
  input  logic            sdi
);
  localparam int FW   = 1 + AW + DW;
  localparam int IW   = $clog2(FW);
  localparam int HDRW = 1 + AW;

  logic [FW-1:0]   sh;
  logic [IW-1:0]   idx;
  logic [DIVW-1:0] dcnt;
  logic            tick;

  assign tick = active && (dcnt == div);
  assign done = tick && sclk && (idx == IW'(FW-1));
  assign cs_n = !active;
  assign sdo  = active && sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      dcnt    <= '0;
      rx_data <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        sh     <= {start_rd, start_addr, start_data};
        idx    <= '0;
        dcnt   <= '0;
        sclk   <= 1'b0;
      end
    end else if (tick) begin
      dcnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
        if (idx >= IW'(HDRW)) rx_data <= {rx_data[DW-2:0], sdi};
      end else begin
        sclk <= 1'b0;
        if (idx == IW'(FW-1)) begin
          active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[FW-2:0], 1'b0};
        end
      end
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pmic_link_bridge.sv
module pmic_link_bridge #(
  parameter int BAW        = 19,
  parameter int DIVW       = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [BAW-1:0] bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           link_sclk,
  output logic           link_cs_n,
  output logic           link_sdo,
  input  logic           link_sdi
);
  import plb_pkg::*;

  localparam int EW = LINK_AW + LINK_DW;
  localparam logic [2:0] IX_CFG = 3'd0, IX_RCMD = 3'd1, IX_RDAT = 3'd2,
                         IX_STS = 3'd3, IX_ERR = 3'd4;

  // configuration
  logic [DIVW-1:0] cfg_div;
  logic [1:0]      cfg_win;
  logic            cfg_new;

  // read state
  logic               rd_pend, rd_busy, err_flag;
  logic [LINK_AW-1:0] rd_addr, rd_echo;
  logic [LINK_DW-1:0] rd_val;

  // named events
  logic             win_sel, win_ok, win_reject, fifo_push, fifo_full, fifo_empty;
  logic             reg_wr, rcmd_wr, rcmd_ok, rd_accept, err_clr;
  logic             rd_start, wr_start, cur_rd;
  logic             link_active, link_done, link_done_rd;
  logic [2:0]       reg_ix;
  logic [OFF_W-1:0] win_off, rcmd_off;
  wr_entry_t        push_ent, head_ent;
  logic [LINK_DW-1:0] rx_data;

  assign reg_ix     = bus_addr[4:2];
  assign win_off    = bus_addr[OFF_W-1:0];
  assign rcmd_off   = bus_wdata[OFF_W-1:0];
  assign win_sel    = bus_valid && bus_write && bus_addr[BAW-1];
  assign win_ok     = plb_in_window(win_off, cfg_win);
  assign win_reject = win_sel && !win_ok;
  assign fifo_push  = win_sel && win_ok && !fifo_full;
  assign reg_wr     = bus_valid && bus_write && !bus_addr[BAW-1];
  assign rcmd_wr    = reg_wr && (reg_ix == IX_RCMD);
  assign rcmd_ok    = plb_in_window(rcmd_off, cfg_win);
  assign rd_accept  = rcmd_wr && rcmd_ok && !rd_busy;
  assign err_clr    = reg_wr && (reg_ix == IX_ERR) && bus_wdata[0];
  assign link_done_rd = link_done && cur_rd;

  assign push_ent.addr = plb_link_addr(win_off, cfg_new);
  assign push_ent.data = bus_wdata[LINK_DW-1:0];

  plb_wfifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (push_ent),
    .pop   (wr_start),
    .dout  (head_ent),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  plb_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_pend     (rd_pend),
    .fifo_empty  (fifo_empty),
    .link_active (link_active),
    .rd_start    (rd_start),
    .wr_start    (wr_start),
    .cur_rd      (cur_rd)
  );

  plb_shifter #(.AW(LINK_AW), .DW(LINK_DW), .DIVW(DIVW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start || wr_start),
    .start_rd   (rd_start),
    .start_addr (rd_start ? rd_addr : head_ent.addr),
    .start_data (rd_start ? '0 : head_ent.data),
    .div        (cfg_div),
    .active     (link_active),
    .done       (link_done),
    .rx_data    (rx_data),
    .sclk       (link_sclk),
    .cs_n       (link_cs_n),
    .sdo        (link_sdo),
    .sdi        (link_sdi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div  <= '0;
      cfg_win  <= '0;
      cfg_new  <= 1'b0;
      rd_pend  <= 1'b0;
      rd_busy  <= 1'b0;
      rd_addr  <= '0;
      rd_echo  <= '0;
      rd_val   <= '0;
      err_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_ix == IX_CFG) begin
        cfg_div <= bus_wdata[DIVW-1:0];
        cfg_win <= bus_wdata[9:8];
        cfg_new <= bus_wdata[10];
      end
      if (rd_accept) begin
        rd_pend <= 1'b1;
        rd_busy <= 1'b1;
        rd_addr <= plb_link_addr(rcmd_off, cfg_new);
      end else if (rd_start) begin
        rd_pend <= 1'b0;
      end
      if (link_done_rd) begin
        rd_busy <= 1'b0;
        rd_val  <= rx_data;
        rd_echo <= rd_addr;
      end
      if (win_reject || (rcmd_wr && !rcmd_ok)) err_flag <= 1'b1;
      else if (err_clr)                        err_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[BAW-1]) begin
      case (reg_ix)
        IX_CFG:  bus_rdata = {21'b0, cfg_new, cfg_win, 8'(cfg_div)};
        IX_RDAT: bus_rdata = {rd_busy, rd_echo, rd_val};
        IX_STS:  bus_rdata = {20'b0, fifo_full, fifo_empty, 10'b0};
        IX_ERR:  bus_rdata = {31'b0, err_flag};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/plb_checker.sv
module plb_checker #(
  parameter int BAW = 19
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_valid,
  input logic           bus_write,
  input logic [BAW-1:0] bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [1:0]     cfg_win,
  input logic           rd_busy,
  input logic           link_done_rd,
  input logic [14:0]    rd_addr,
  input logic           fifo_push,
  input logic           fifo_full,
  input logic           fifo_empty,
  input logic           rd_start,
  input logic           wr_start,
  input logic           err_flag,
  input logic           link_sclk,
  input logic           link_cs_n
);
  import plb_pkg::*;

  a_r2_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_addr[BAW-1] && bus_addr[4:2] == 3'd1 && !rd_busy
     && plb_in_window(bus_wdata[16:0], cfg_win)) |=> rd_busy);

  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !link_done_rd) |=> rd_busy);

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  a_r7_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[BAW-1] && !plb_in_window(bus_addr[16:0], cfg_win))
    |=> err_flag);

  a_r7_reject_nopush: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[BAW-1] && !plb_in_window(bus_addr[16:0], cfg_win)) |-> !fifo_push);

  a_r8_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> fifo_empty);

  a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, wr_start}));

  a_r9_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> !link_sclk);

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !link_done_rd) |=> $stable(rd_addr));
endmodule

bind pmic_link_bridge plb_checker #(.BAW(BAW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .cfg_win      (cfg_win),
  .rd_busy      (rd_busy),
  .link_done_rd (link_done_rd),
  .rd_addr      (rd_addr),
  .fifo_push    (fifo_push),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .rd_start     (rd_start),
  .wr_start     (wr_start),
  .err_flag     (err_flag),
  .link_sclk    (link_sclk),
  .link_cs_n    (link_cs_n)
);

// File: tb/pmic_link_bridge_tb.sv
`timescale 1ns/1ps
module pmic_link_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        link_sclk, link_cs_n, link_sdo;
  logic        link_sdi = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  pmic_link_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .link_sclk(link_sclk), .link_cs_n(link_cs_n), .link_sdo(link_sdo), .link_sdi(link_sdi)
  );

  // behavioural slave and frame reference
  typedef struct { bit rw; bit [14:0] a; bit [15:0] d; } frame_t;
  frame_t exp_q[$];
  frame_t got_q[$];
  bit [15:0] smem [int];
  bit [31:0] ssh;
  bit [15:0] srd;
  int        sk = 0;

  function automatic bit [15:0] sdef(input bit [14:0] a);
    return {a, 1'b1} ^ 16'h3C3C;
  endfunction
  function automatic bit [15:0] sval(input bit [14:0] a);
    return smem.exists(int'(a)) ? smem[int'(a)] : sdef(a);
  endfunction

  always @(negedge link_cs_n) sk = 0;
  always @(posedge link_sclk) begin
    ssh = {ssh[30:0], link_sdo};
    sk++;
    if (sk == 16 && ssh[15]) srd = sval(ssh[14:0]);
    if (sk >= 16 && sk < 32 && ssh[31-(sk-16)+16-16+0] == ssh[31-(sk-16)+16-16+0]) begin
      if (sk == 16) link_sdi = ssh[15] ? srd[15] : 1'b0;
      else          link_sdi = ssh[31-(sk-16)] ? 1'b0 : 1'b0;
    end
  end
  // data drive for read frames kept separate for clarity
  always @(posedge link_sclk) begin
    #0.1;
    if (sk >= 16 && sk < 32 && rd_frame) link_sdi = srd[31-sk];
  end
  bit rd_frame = 0;
  always @(posedge link_sclk) begin
    #0.05;
    if (sk == 16) rd_frame = ssh[15];
    if (sk == 32) begin
      frame_t f;
      f.rw = ssh[31];
      f.a  = ssh[30:16];
      f.d  = ssh[31] ? srd : ssh[15:0];
      if (!ssh[31]) smem[int'(ssh[30:16])] = ssh[15:0];
      got_q.push_back(f);
      rd_frame = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input bit [18:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input bit [18:0] a, output bit [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_valid = 0;
  endtask

  function automatic bit [18:0] ra(input int ix); return 19'(ix * 4); endfunction
  function automatic bit [18:0] wa(input bit [16:0] off); return {2'b10, off}; endfunction
  function automatic bit [31:0] cfgv(input int dv, input int win, input bit nw);
    return {21'b0, nw, 2'(win), 8'(dv)};
  endfunction

  task automatic wait_idle();
    bit [31:0] s, r;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      rd(ra(3), s); rd(ra(2), r);
      if (s[10] && !r[31] && link_cs_n) begin
        repeat (4) @(negedge clk);
        return;
      end
    end
    chk(0, "idle-wait", 0, 1);
  endtask

  task automatic cmp_frames(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      frame_t e, g;
      e = exp_q.pop_front(); g = got_q.pop_front();
      chk(e.rw == g.rw && e.a == g.a && e.d == g.d, req,
          {g.rw, g.a, g.d}, {e.rw, e.a, e.d});
    end
    exp_q.delete(); got_q.delete();
  endtask

  function automatic frame_t fr(input bit rw, input bit [14:0] a, input bit [15:0] d);
    frame_t f; f.rw = rw; f.a = a; f.d = d; return f;
  endfunction

  task automatic timed_read(input int dv, input bit [16:0] off, input bit [14:0] la, input string req);
    bit [31:0] r;
    int n = 0;
    wr(ra(1), {15'b0, off});
    rd(ra(2), r);
    chk(r[31] == 1'b1, {req, " busy set R2"}, r[31], 1);
    while (r[31] && n < 20000) begin
      @(negedge clk); n++;
      rd(ra(2), r);
    end
    chk(n == 1 + 64 * (dv + 1), {req, " latency R2"}, n, 1 + 64 * (dv + 1));
    chk(r == {1'b0, la, sval(la)}, {req, " data/echo R3 R4"}, r, {1'b0, la, sval(la)});
    exp_q.push_back(fr(1, la, sval(la)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done_flag) begin
      done_flag = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(ra(2), r); chk(r == 0, "R1 rddata", r, 0);
    rd(ra(3), r); chk(r == 32'h400, "R1 R6 status", r, 32'h400);
    rd(ra(4), r); chk(r == 0, "R1 error", r, 0);
    chk(link_cs_n == 1 && link_sclk == 0, "R1 link idle", {link_cs_n, link_sclk}, 2'b10);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 R9: simple write then timed read, div 0, 4K, old map
    wr(ra(0), cfgv(0, 0, 0));
    wr(wa(17'h010), 32'hFFFF_1234);
    exp_q.push_back(fr(0, 15'h010, 16'h1234));
    wait_idle();
    cmp_frames("R5 R9 write frame");
    timed_read(0, 17'h010, 15'h010, "old map");
    wait_idle();
    cmp_frames("R9 read frame");

    // R7 out-of-range in 4K window
    wr(wa(17'h1000), 32'h5555);
    rd(ra(4), r); chk(r[0] == 1, "R7 window write err", r, 1);
    wr(ra(4), 32'h1);
    rd(ra(4), r); chk(r[0] == 0, "R7 err clear", r, 0);
    wr(ra(1), 32'h1000);
    rd(ra(2), r); chk(r[31] == 0, "R7 rejected read not busy", r[31], 0);
    rd(ra(4), r); chk(r[0] == 1, "R7 read cmd err", r, 1);
    wr(ra(3), 32'h0);
    rd(ra(4), r); chk(r[0] == 1, "R7 sticky", r, 1);
    wr(ra(4), 32'h1);
    wait_idle();
    cmp_frames("R7 no frame");

    // R7 R4: 16K window, old map
    wr(ra(0), cfgv(1, 1, 0));
    timed_read(1, 17'h3FFC, 15'h3FFC, "16K edge");
    wr(wa(17'h4000), 32'h1);
    rd(ra(4), r); chk(r[0] == 1, "R7 16K limit", r, 1);
    wr(ra(4), 32'h1);
    wait_idle();
    cmp_frames("R7 16K frames");

    // R4 new map, 128K window
    wr(ra(0), cfgv(2, 2, 1));
    timed_read(2, 17'h1F6A4, 15'h7DA9, "new map");
    wr(wa(17'h1FFFC), 32'hBEEF);
    exp_q.push_back(fr(0, 15'h7FFF, 16'hBEEF));
    wait_idle();
    cmp_frames("R4 new map frames");

    // R8 order: writes then read waits; R10 second command ignored
    wr(ra(0), cfgv(3, 2, 1));
    wr(wa(17'h00100), 32'hA001);
    wr(wa(17'h00104), 32'hA002);
    wr(wa(17'h00108), 32'hA003);
    wr(ra(1), 32'h00104);
    wr(ra(1), 32'h00200);
    exp_q.push_back(fr(0, 15'h040, 16'hA001));
    exp_q.push_back(fr(0, 15'h041, 16'hA002));
    exp_q.push_back(fr(0, 15'h042, 16'hA003));
    exp_q.push_back(fr(1, 15'h041, 16'hA002));
    wait_idle();
    rd(ra(2), r);
    chk(r == {1'b0, 15'h041, 16'hA002}, "R10 R8 echo of first command", r, {1'b0, 15'h041, 16'hA002});
    cmp_frames("R8 R10 frame order");

    // R6 R5: fill queue, drop overflow
    wr(ra(0), cfgv(15, 2, 0));
    for (int i = 0; i < 17; i++) begin
      wr(wa(17'(i * 4)), 32'(16'hC000 + i));
      exp_q.push_back(fr(0, 15'(i * 4), 16'(16'hC000 + i)));
    end
    rd(ra(3), r); chk(r == 32'h800, "R6 full flag", r, 32'h800);
    wr(wa(17'h0FC), 32'hDEAD);
    rd(ra(4), r); chk(r[0] == 0, "R5 full drop no error", r, 0);
    wait_idle();
    rd(ra(3), r); chk(r == 32'h400, "R6 empty again", r, 32'h400);
    cmp_frames("R5 R8 drained order");

    done_flag = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule